// File: doc/BRIEF.md
# Bus Segment Direction Controller for a Two-Segment SCSI Repeater

This block steers the control-line drivers of a repeater that joins two SCSI bus segments, called side A and side B. It samples BSY, SEL and I/O on both segments, and it takes a flag from the external arbitration logic that says which segment holds the arbitration winner. From these it decides, for each group of lines, whether the repeater drives that group onto side A, onto side B, or onto neither. The groups are: SEL alone, the initiator group (ACK, ATN and SEL once connected), the target group (REQ, MSG, C/D, I/O) and BSY. It also enables the external data transceivers and gives them a data-flow direction.

Four states sequence the work: ARB (idle and arbitration, all drivers off), SEL1 (a selection is in progress and only SEL is forwarded), SEL2 (initiator and target sit on different segments) and XFER (connected information phases). The transitions are:
- ARB→SEL1 when SEL is seen on either side.
- SEL1→SEL2 when the far segment answers with BSY while the winner still holds SEL.
- SEL1→ARB on bus free.
- SEL2→XFER either at once for a selection or on release of SEL for a reselection.
- SEL2→ARB and XFER→ARB on bus free.

Bus free means that no BSY or SEL has been seen on either side for 400 ns, measured by a reloadable down-counter of clock cycles. Every bus input passes through a two-flop synchronizer.

Top module: `bus_dir_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in ARB, clears the winner-side and reselect flags and drives every enable output to 0 while it is held.
- R2: In ARB every enable output is 0. The first SEL seen on either side moves the block to SEL1 and latches `win_b` (1 = winner on side B). Outside ARB, `win_b` has no effect.
- R3: In SEL1 only SEL is forwarded: toward A (`sel_to_a`) when the winner is on B, and toward B when it is on A. If the target answers on the winner's own side, the block stays in SEL1 until bus free and then returns to ARB.
- R4: SEL1→SEL2 happens when BSY is seen on the far side while the winner's SEL is still seen. At that moment the winner-side I/O level is latched as the reselect flag (1 = reselection, 0 = selection).
- R5: The initiator is on B when winner flag XOR reselect flag is 1. With the initiator on B, the initiator group drives A and the target group drives B. With the initiator on A, both directions are reversed. In XFER, SEL follows the initiator group.
- R6: For a selection, the block passes from SEL2 to XFER on the next clock. The data enable is 1 in both states, and BSY is driven the same way as the target group.
- R7: For a reselection, the block stays in SEL2 while the winner's SEL is seen, with the data enable at 0 and BSY driven opposite to the target group. When that SEL is released, it enters XFER and BSY then follows the target group.
- R8: `dat_to_b` is 1 when data flows toward side B. Data flows toward the initiator's side when the target-side I/O is 1 and toward the target's side when it is 0. `dat_to_b` is 0 whenever `dat_en` is 0.
- R9: The bus-free window is CLK_HZ × 400 ns cycles. XFER, together with its drivers, holds until no BSY or SEL has been seen on either side for the whole window. Any BSY or SEL seen during the window restarts it.
- R10: Each bus input crosses two synchronizer flops. A SEL arriving in ARB changes the outputs at the third rising clock edge, not the second. No group is ever enabled toward both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_bsy | input | 1 | BSY received on side A, 1 = asserted |
| a_sel | input | 1 | SEL received on side A |
| a_io | input | 1 | I/O received on side A |
| b_bsy | input | 1 | BSY received on side B |
| b_sel | input | 1 | SEL received on side B |
| b_io | input | 1 | I/O received on side B |
| win_b | input | 1 | Arbitration winner on side B when 1 |
| sel_to_a | output | 1 | Drive SEL onto side A |
| sel_to_b | output | 1 | Drive SEL onto side B |
| ini_to_a | output | 1 | Drive initiator group onto side A |
| ini_to_b | output | 1 | Drive initiator group onto side B |
| tgt_to_a | output | 1 | Drive target group onto side A |
| tgt_to_b | output | 1 | Drive target group onto side B |
| bsy_to_a | output | 1 | Drive BSY onto side A |
| bsy_to_b | output | 1 | Drive BSY onto side B |
| dat_en | output | 1 | Data transceiver enable |
| dat_to_b | output | 1 | Data flows toward side B when 1 |

## Verification
Properties check several rules on every cycle:
- No line group is ever driven both ways.
- The data enable stays off during a pending reselection, and SEL2 holds while the winner keeps SEL.
- The winner flag is frozen outside ARB.
- Seen bus activity reloads the idle counter.
- XFER is left only on a bus-free indication.

The actual direction chosen for each of the three topologies, the BSY hand-over, the data direction, the synchronizer latency and the exact length of the idle window (including a restart by a short BSY pulse) can only be shown by the bench's scenarios.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;

    typedef enum logic [1:0] {
        ST_ARB  = 2'd0,
        ST_SEL1 = 2'd1,
        ST_SEL2 = 2'd2,
        ST_XFER = 2'd3
    } bdc_state_e;

    // Synchronized view of one bus segment
    typedef struct packed {
        logic bsy;
        logic sel;
        logic io;
    } bdc_side_t;

    // Driver enable pair of one line group
    typedef struct packed {
        logic to_a;
        logic to_b;
    } bdc_dir_t;

    localparam bdc_dir_t DIR_OFF = '{to_a: 1'b0, to_b: 1'b0};

    function automatic bdc_dir_t dir_toward(input logic to_b);
        bdc_dir_t d;
        d.to_a = ~to_b;
        d.to_b = to_b;
        return d;
    endfunction

endpackage

// File: rtl/bdc_sync.sv
`timescale 1ns/1ps
module bdc_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bdc_idle_timer.sv
`timescale 1ns/1ps
module bdc_idle_timer
    import bdc_pkg::*;
#(
    parameter int WIN = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  bdc_side_t a_s,
    input  bdc_side_t b_s,
    output logic      bus_free
);

    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] LOAD = CW'(WIN);

    logic          busy;
    logic [CW-1:0] cnt_q;

    assign busy = a_s.bsy | a_s.sel | b_s.bsy | b_s.sel;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= LOAD;
        else if (busy)         cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign bus_free = (cnt_q == '0) && !busy;

    AST_RELOAD_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cnt_q == LOAD)); // R9

endmodule

// File: rtl/bdc_fsm.sv
`timescale 1ns/1ps
module bdc_fsm
    import bdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bdc_side_t a_s,
    input  bdc_side_t b_s,
    input  logic      win_b_s,
    input  logic      bus_free,
    output bdc_dir_t  sel_d,
    output bdc_dir_t  ini_d,
    output bdc_dir_t  tgt_d,
    output bdc_dir_t  bsy_d,
    output logic      dat_en,
    output logic      dat_to_b
);

    bdc_state_e state_q, state_n;
    logic       side_q, side_n;     // winner on B
    logic       resel_q, resel_n;   // reselection in progress

    logic near_sel, near_io, far_bsy, ini_b, tgt_io;

    assign near_sel = side_q ? b_s.sel : a_s.sel;
    assign near_io  = side_q ? b_s.io  : a_s.io;
    assign far_bsy  = side_q ? a_s.bsy : b_s.bsy;
    assign ini_b    = side_q ^ resel_q;
    assign tgt_io   = ini_b ? a_s.io : b_s.io;

    // next-state and latch decisions
    always_comb begin
        state_n = state_q;
        side_n  = side_q;
        resel_n = resel_q;
        unique case (state_q)
            ST_ARB: begin
                if (a_s.sel || b_s.sel) begin
                    state_n = ST_SEL1;
                    side_n  = win_b_s;
                    resel_n = 1'b0;
                end
            end
            ST_SEL1: begin
                if (far_bsy && near_sel) begin
                    state_n = ST_SEL2;
                    resel_n = near_io;
                end else if (bus_free) begin
                    state_n = ST_ARB;
                end
            end
            ST_SEL2: begin
                if (bus_free) begin
                    state_n = ST_ARB;
                    resel_n = 1'b0;
                end else if (!resel_q || !near_sel) begin
                    state_n = ST_XFER;
                end
            end
            ST_XFER: begin
                if (bus_free) begin
                    state_n = ST_ARB;
                    resel_n = 1'b0;
                end
            end
            default: state_n = ST_ARB;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARB;
            side_q  <= 1'b0;
            resel_q <= 1'b0;
        end else begin
            state_q <= state_n;
            side_q  <= side_n;
            resel_q <= resel_n;
        end
    end

    // outputs
    always_comb begin
        sel_d  = DIR_OFF;
        ini_d  = DIR_OFF;
        tgt_d  = DIR_OFF;
        bsy_d  = DIR_OFF;
        dat_en = 1'b0;
        unique case (state_q)
            ST_ARB: begin
                dat_en = 1'b0;
            end
            ST_SEL1: begin
                sel_d = dir_toward(~side_q);
            end
            ST_SEL2: begin
                sel_d  = dir_toward(~side_q);
                ini_d  = dir_toward(~ini_b);
                tgt_d  = dir_toward(ini_b);
                bsy_d  = resel_q ? dir_toward(~ini_b) : dir_toward(ini_b);
                dat_en = ~resel_q;
            end
            ST_XFER: begin
                ini_d  = dir_toward(~ini_b);
                sel_d  = dir_toward(~ini_b);
                tgt_d  = dir_toward(ini_b);
                bsy_d  = dir_toward(ini_b);
                dat_en = 1'b1;
            end
            default: dat_en = 1'b0;
        endcase
        dat_to_b = dat_en & ~(tgt_io ^ ini_b);
    end

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_d.to_a, sel_d.to_b}) && $onehot0({ini_d.to_a, ini_d.to_b}) &&
        $onehot0({tgt_d.to_a, tgt_d.to_b}) && $onehot0({bsy_d.to_a, bsy_d.to_b})); // R10

    AST_XFER_EXIT_FREE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && !bus_free) |=> (state_q == ST_XFER)); // R9

    AST_RESEL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEL2 && resel_q) |-> !dat_en); // R7

    AST_RESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEL2 && resel_q && near_sel && !bus_free) |=> (state_q == ST_SEL2)); // R7

    AST_SIDE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_ARB) |=> $stable(side_q)); // R2

endmodule

// File: rtl/bus_dir_ctrl.sv
`timescale 1ns/1ps
module bus_dir_ctrl
    import bdc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_bsy,
    input  logic a_sel,
    input  logic a_io,
    input  logic b_bsy,
    input  logic b_sel,
    input  logic b_io,
    input  logic win_b,
    output logic sel_to_a,
    output logic sel_to_b,
    output logic ini_to_a,
    output logic ini_to_b,
    output logic tgt_to_a,
    output logic tgt_to_b,
    output logic bsy_to_a,
    output logic bsy_to_b,
    output logic dat_en,
    output logic dat_to_b
);

    localparam longint WIN_RAW = (longint'(CLK_HZ) * 64'sd400) / 64'sd1_000_000_000;
    localparam int     WIN     = (WIN_RAW < 1) ? 1 : int'(WIN_RAW);
    localparam int     NIN     = 7;

    logic [NIN-1:0] raw, syn;
    bdc_side_t      a_s, b_s;
    logic           bus_free;
    bdc_dir_t       sel_d, ini_d, tgt_d, bsy_d;

    assign raw = {win_b, a_bsy, a_sel, a_io, b_bsy, b_sel, b_io};

    bdc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign a_s = '{bsy: syn[5], sel: syn[4], io: syn[3]};
    assign b_s = '{bsy: syn[2], sel: syn[1], io: syn[0]};

    bdc_idle_timer #(.WIN(WIN)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .a_s      (a_s),
        .b_s      (b_s),
        .bus_free (bus_free)
    );

    bdc_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .a_s      (a_s),
        .b_s      (b_s),
        .win_b_s  (syn[6]),
        .bus_free (bus_free),
        .sel_d    (sel_d),
        .ini_d    (ini_d),
        .tgt_d    (tgt_d),
        .bsy_d    (bsy_d),
        .dat_en   (dat_en),
        .dat_to_b (dat_to_b)
    );

    assign sel_to_a = sel_d.to_a;
    assign sel_to_b = sel_d.to_b;
    assign ini_to_a = ini_d.to_a;
    assign ini_to_b = ini_d.to_b;
    assign tgt_to_a = tgt_d.to_a;
    assign tgt_to_b = tgt_d.to_b;
    assign bsy_to_a = bsy_d.to_a;
    assign bsy_to_b = bsy_d.to_b;

endmodule

// File: tb/test_bus_dir_ctrl.sv
`timescale 1ns/1ps
module test_bus_dir_ctrl;

    localparam int CLK_PERIOD = 40;          // 25 MHz -> idle window of 10 cycles
    localparam int CLK_HZ     = 25_000_000;
    localparam int NVEC       = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [6:0] drv = '0;   // {win_b, a_bsy, a_sel, a_io, b_bsy, b_sel, b_io}
    logic sel_to_a, sel_to_b, ini_to_a, ini_to_b, tgt_to_a, tgt_to_b;
    logic bsy_to_a, bsy_to_b, dat_en, dat_to_b;
    logic [9:0] got;
    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_dir_ctrl #(.CLK_HZ(CLK_HZ)) i_bus_dir_ctrl (
        .clk(clk), .rst(rst),
        .a_bsy(drv[5]), .a_sel(drv[4]), .a_io(drv[3]),
        .b_bsy(drv[2]), .b_sel(drv[1]), .b_io(drv[0]), .win_b(drv[6]),
        .sel_to_a(sel_to_a), .sel_to_b(sel_to_b),
        .ini_to_a(ini_to_a), .ini_to_b(ini_to_b),
        .tgt_to_a(tgt_to_a), .tgt_to_b(tgt_to_b),
        .bsy_to_a(bsy_to_a), .bsy_to_b(bsy_to_b),
        .dat_en(dat_en), .dat_to_b(dat_to_b)
    );

    assign got = {sel_to_a, sel_to_b, ini_to_a, ini_to_b, tgt_to_a, tgt_to_b,
                  bsy_to_a, bsy_to_b, dat_en, dat_to_b};

    // {inputs[6:0], hold[7:0], expected[9:0], requirement[7:0]}
    // expected = {sel a,b | ini a,b | tgt a,b | bsy a,b | dat_en, dat_to_b}
    localparam logic [32:0] VEC [NVEC] = '{
        {7'b0000000, 8'd6,  10'b00_00_00_00_00, 8'd2},  // R2 idle in ARB
        {7'b0110000, 8'd6,  10'b01_00_00_00_00, 8'd3},  // R3 winner A, SEL toward B
        {7'b0010100, 8'd6,  10'b01_01_10_10_11, 8'd6},  // R6 selection reaches XFER
        {7'b0000101, 8'd6,  10'b01_01_10_10_10, 8'd8},  // R8 I/O=1 data toward A
        {7'b0000000, 8'd4,  10'b01_01_10_10_11, 8'd9},  // R9 still driving in window
        {7'b0000000, 8'd12, 10'b00_00_00_00_00, 8'd9},  // R9 bus free -> ARB
        {7'b1000111, 8'd6,  10'b10_00_00_00_00, 8'd3},  // R3 winner B, SEL toward A
        {7'b1100011, 8'd6,  10'b10_01_10_01_00, 8'd7},  // R7 reselection held in SEL2
        {7'b0000101, 8'd6,  10'b01_01_10_10_10, 8'd7},  // R7 BSY handed over; R2 win_b ignored
        {7'b0000000, 8'd16, 10'b00_00_00_00_00, 8'd9},  // R9
        {7'b1000110, 8'd6,  10'b10_00_00_00_00, 8'd3},  // R3
        {7'b1000110, 8'd10, 10'b10_00_00_00_00, 8'd3},  // R3 same-side target stays SEL1
        {7'b0000000, 8'd16, 10'b00_00_00_00_00, 8'd3},  // R3 back to ARB
        {7'b1000110, 8'd6,  10'b10_00_00_00_00, 8'd4},  // R4 into SEL1
        {7'b1100010, 8'd6,  10'b10_10_01_01_10, 8'd5},  // R5 initiator on B
        {7'b0100000, 8'd6,  10'b10_10_01_01_10, 8'd5},  // R5 held while BSY
        {7'b0000000, 8'd16, 10'b00_00_00_00_00, 8'd9}   // R9
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        tick(3);
        check("R1 reset outputs", got, 10'b0);
        rst = 1'b0;
        tick(1);

        for (int v = 0; v < NVEC; v++) begin
            drv = VEC[v][32:26];
            tick(int'(VEC[v][25:18]));
            check($sformatf("R%0d vec %0d", VEC[v][7:0], v), got, VEC[v][17:8]);
        end

        // R10: synchronizer latency, response on the third edge
        drv = 7'b0010000;
        tick(2);
        check("R10 before third edge", got, 10'b0);
        tick(1);
        check("R10 at third edge", got, 10'b01_00_00_00_00);
        drv = 7'b0000000;
        tick(16);
        check("R3 SEL1 exits on bus free", got, 10'b0);

        // R9: a short BSY pulse restarts the idle window
        drv = 7'b0110000; tick(6);
        drv = 7'b0010100; tick(6);
        check("R6 XFER before pulse", got, 10'b01_01_10_10_11);
        drv = 7'b0000000; tick(6);
        drv = 7'b0000100; tick(1);
        drv = 7'b0000000; tick(8);
        check("R9 window restarted", got, 10'b01_01_10_10_11);
        tick(12);
        check("R9 ARB after restarted window", got, 10'b0);

        // R1: reset in the middle of a transfer
        drv = 7'b1000110; tick(6);
        drv = 7'b1100010; tick(6);
        check("R5 XFER before reset", got, 10'b10_10_01_01_10);
        rst = 1'b1;
        tick(2);
        check("R1 reset during XFER", got, 10'b0);
        drv = 7'b0000000;
        tick(1);
        rst = 1'b0;
        tick(6);
        check("R1 idle after reset", got, 10'b0);

        // R2: win_b alone does nothing in ARB
        drv = 7'b1000000;
        tick(6);
        check("R2 win_b without SEL", got, 10'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule